// File: doc/BRIEF.md
# Fractional-Frequency PWM Generator

This block produces a pulse-width modulated output whose rate is set by a fractional step, not by an integer terminal count. A 16-bit phase accumulator adds a programmable step on every clock, so the waveform frequency is the clock frequency times the step divided by 65536. A period boundary occurs whenever the accumulator carries out of its top bit. The duty cycle comes from comparing the upper byte of the accumulator with an 8-bit threshold. The output is high while that byte is above the threshold, so a smaller threshold gives a longer high time.

Software sees one 32-bit control word. It holds a run enable, an apply request, the step and the threshold. Step and threshold writes go into shadow storage. They move to the active copy only when software raises the apply request and the next period boundary arrives. While the generator is stopped, a pending request is applied at once. The apply request reads back as 1 until the hardware has taken the new values, so a read-modify-write keeps whatever enable state it read.

Top module: `fracpwm_top`

## Requirements
- R1: After reset the read word is all zeros and `pwm_out` is low.
- R2: A write stores bit 31 as the run enable and bits 23:8 / 7:0 as the shadow step and threshold. The read word returns the enable in bit 31, the pending apply state in bit 30, zeros in bits 29:24, and the shadow step and threshold in bits 23:0.
- R3: While running, the accumulator advances by the active step every clock, wrapping modulo 65536. A step of 0x4000 gives a 4-clock period and a step of 0x2000 an 8-clock period.
- R4: While running, `pwm_out` is high exactly when accumulator bits 15:8 are strictly greater than the active threshold. For example, step 0x4000 with threshold 0x50 is high 2 clocks of every 4, and step 0x2000 with threshold 0x50 is high 5 of every 8.
- R5: While running, a requested update changes the active step and threshold only on the clock where the accumulator carries out. Until then the old waveform continues.
- R6: Writing bit 30 as 1 sets the pending flag. It reads back as 1 until the active settings are loaded, then returns to 0 by itself.
- R7: While the generator is not running, a pending update is applied on the next clock.
- R8: Clearing the enable forces `pwm_out` low immediately and holds the accumulator at zero. After enable is set again, there is one clock of start-up, and then counting restarts from zero with the output low for that first zero-phase clock.
- R9: A write with bit 30 clear updates the shadow readback but leaves the waveform unchanged.
- R10: A step of 0x8000 with threshold 0 toggles `pwm_out` on every clock, a 2-clock period.
- R11: A threshold of 0xFF keeps `pwm_out` low at every phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench pushes for the clock where the carry-out occurs, to check that a requested step change waits for it. A design that applied the change at once would show a truncated period, which the cycle-accurate scoreboard catches. It enables and requests an update in the same write from a stopped state. A design that only applied updates at a carry would then sit at step zero forever, with no carry ever arriving. It also rewrites fields with the apply bit clear, and a design that loaded them anyway would shift the duty count. It re-enables after a stop, so a design that kept the old phase would put the first high clock in the wrong place. The extreme threshold 0xFF and the fastest step 0x8000 show up off-by-one errors in the compare as stray or missing high clocks.

// File: rtl/fracpwm_pkg.sv
package fracpwm_pkg;
  localparam int unsigned ACC_W    = 16;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned REQ_BIT  = 30;
  localparam int unsigned CFG_W    = ACC_W + DIV_W;

  // step occupies the upper field, threshold the lower field of the word
  typedef struct packed {
    logic [ACC_W-1:0] step;
    logic [DIV_W-1:0] thr;
  } cfg_t;
endpackage

// File: rtl/fracpwm_regs.sv
module fracpwm_regs
  import fracpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             commit,
  output cfg_t             shadow,
  output logic             en,
  output logic             pending
);
  cfg_t shadow_d;
  logic en_d;
  logic pending_d;

  always_comb begin
    shadow_d  = shadow;
    en_d      = en;
    pending_d = pending;
    if (commit) pending_d = 1'b0;
    if (wr_en) begin
      shadow_d = cfg_t'(wr_data[CFG_W-1:0]);
      en_d     = wr_data[EN_BIT];
      if (wr_data[REQ_BIT]) pending_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= '0;
      en      <= 1'b0;
      pending <= 1'b0;
    end else if (wr_en || commit) begin
      shadow  <= shadow_d;
      en      <= en_d;
      pending <= pending_d;
    end
  end
endmodule

// File: rtl/fracpwm_phase.sv
module fracpwm_phase #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] step,
  output logic         run,
  output logic [W-1:0] acc,
  output logic         wrap
);
  logic [W:0]   sum;
  logic [W-1:0] acc_d;

  always_comb begin
    sum   = {1'b0, acc} + {1'b0, step};
    wrap  = run & sum[W];
    acc_d = run ? sum[W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      acc <= '0;
    end else begin
      run <= en;
      acc <= acc_d;
    end
  end
endmodule

// File: rtl/fracpwm_duty.sv
module fracpwm_duty
  import fracpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             wrap,
  input  logic             pending,
  input  cfg_t             shadow,
  input  logic [DIV_W-1:0] phase_top,
  output logic             commit,
  output cfg_t             active,
  output logic             pwm_out
);
  // a boundary is either a carry-out or any clock while stopped
  always_comb begin
    commit  = pending & (~run | wrap);
    pwm_out = en & run & (phase_top > active.thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= '0;
    else if (commit) active <= shadow;
  end
endmodule

// File: rtl/fracpwm_top.sv
module fracpwm_top
  import fracpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             pwm_out
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  cfg_t             shadow;
  cfg_t             active;
  logic             en;
  logic             pending;
  logic             commit;
  logic             run;
  logic             wrap;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] act_step;
  logic [DIV_W-1:0] act_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  fracpwm_regs i_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_data(wr_data),
    .commit(commit), .shadow(shadow), .en(en), .pending(pending)
  );

  fracpwm_phase #(.W(ACC_W)) i_phase (
    .clk(clk), .rst_n(rst_core_n), .en(en), .step(active.step),
    .run(run), .acc(acc), .wrap(wrap)
  );

  fracpwm_duty i_duty (
    .clk(clk), .rst_n(rst_core_n), .en(en), .run(run), .wrap(wrap),
    .pending(pending), .shadow(shadow), .phase_top(acc[ACC_W-1 -: DIV_W]),
    .commit(commit), .active(active), .pwm_out(pwm_out)
  );

  assign act_step = active.step;
  assign act_thr  = active.thr;

  always_comb begin
    rd_data            = '0;
    rd_data[EN_BIT]    = en;
    rd_data[REQ_BIT]   = pending;
    rd_data[CFG_W-1:0] = shadow;
  end
endmodule

// File: rtl/fracpwm_checker.sv
module fracpwm_checker
  import fracpwm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             pwm_out,
  input logic             commit,
  input logic [ACC_W-1:0] act_step,
  input logic [DIV_W-1:0] act_thr
);
  a_r2_enable_tracks_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[EN_BIT] == $past(wr_data[EN_BIT]));

  a_r9_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[CFG_W-1:0]));

  a_r8_low_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[EN_BIT] |-> !pwm_out);

  a_r5_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_step) && $stable(act_thr)));

  a_r6_pending_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(wr_en && wr_data[REQ_BIT])) |=> !rd_data[REQ_BIT]);
endmodule

bind fracpwm_top fracpwm_checker i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pwm_out(pwm_out), .commit(commit),
  .act_step(act_step), .act_thr(act_thr)
);

// File: tb/test_fracpwm_top.sv
`timescale 1ns/1ps
module test_fracpwm_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        pwm_out;

  int checks;
  int errors;
  bit done;

  typedef struct { logic pwm; logic [31:0] rd; } exp_t;
  exp_t sb_q[$];

  fracpwm_top i_fracpwm_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference state built from the requirements
  logic        m_en, m_pend, m_run;
  logic [15:0] m_sstep, m_astep, m_acc;
  logic [7:0]  m_sthr, m_athr;

  always @(posedge clk) begin
    exp_t e;
    logic carry, cm;
    logic [16:0] s;
    if (!rst_n) begin
      m_en = 0; m_pend = 0; m_run = 0; m_sstep = 0; m_astep = 0;
      m_acc = 0; m_sthr = 0; m_athr = 0;
    end else begin
      s     = {1'b0, m_acc} + {1'b0, m_astep};
      carry = m_run && s[16];
      cm    = m_pend && (!m_run || carry);
      m_acc = m_run ? s[15:0] : 16'h0;
      m_run = m_en;
      if (cm) begin m_astep = m_sstep; m_athr = m_sthr; m_pend = 0; end
      if (wr_en) begin
        m_en = wr_data[31]; m_sstep = wr_data[23:8]; m_sthr = wr_data[7:0];
        if (wr_data[30]) m_pend = 1;
      end
    end
    e.pwm = m_en && m_run && (m_acc[15:8] > m_athr);
    e.rd  = {m_en, m_pend, 6'b0, m_sstep, m_sthr};
    sb_q.push_back(e);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0 && !done) begin
      e = sb_q.pop_front();
      checks++;
      if (pwm_out !== e.pwm) begin
        errors++;
        $display("FAIL R4 scoreboard pwm_out actual=%0b expected=%0b t=%0t", pwm_out, e.pwm, $time);
      end
      checks++;
      if (rd_data !== e.rd) begin
        errors++;
        $display("FAIL R2 scoreboard rd_data actual=%h expected=%h t=%0t", rd_data, e.rd, $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic en, input logic req, input logic [15:0] st, input logic [7:0] th);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {en, req, 6'b0, st, th};
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) c++;
    end
  endtask

  task automatic wait_apply(output int n);
    n = 0;
    while (rd_data[30] && n < 100) begin @(negedge clk); n++; end
  endtask

  initial begin
    int c, n;
    logic prev;
    logic [3:0] seq;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset pwm_out", int'(pwm_out), 0);
    chk("R1 reset rd_data", int'(rd_data), 0);

    // stopped: apply request lands on the next clock
    wr(1'b0, 1'b1, 16'h4000, 8'h50);
    chk("R6 pending visible", int'(rd_data[30]), 1);
    @(negedge clk);
    chk("R7 applied while stopped", int'(rd_data[30]), 0);

    // start with read-modify-write, apply bit clear
    wr(1'b1, 1'b0, 16'h4000, 8'h50);
    chk("R2 enable readback", int'(rd_data[31]), 1);
    repeat (2) @(negedge clk);
    count_high(8, c);
    chk("R3 R4 step 0x4000 thr 0x50 high of 8", c, 4);

    // field rewrite without apply
    wr(1'b1, 1'b0, 16'h2000, 8'h50);
    chk("R2 shadow step readback", int'(rd_data[23:8]), 16'h2000);
    count_high(8, c);
    chk("R9 waveform unchanged", c, 4);

    // request apply while running
    wr(1'b1, 1'b1, 16'h2000, 8'h50);
    wait_apply(n);
    chk("R6 pending clears within one period", int'(n <= 4), 1);
    count_high(16, c);
    chk("R3 R5 step 0x2000 thr 0x50 high of 16", c, 10);

    // same enable and apply together from stopped
    wr(1'b0, 1'b0, 16'h2000, 8'h50);
    wr(1'b1, 1'b1, 16'h4000, 8'h50);
    wait_apply(n);
    repeat (2) @(negedge clk);
    count_high(8, c);
    chk("R7 enable plus apply from stop", c, 4);

    // threshold at maximum
    wr(1'b1, 1'b1, 16'h2000, 8'hFF);
    wait_apply(n);
    @(negedge clk);
    count_high(16, c);
    chk("R11 thr 0xFF never high", c, 0);

    // fastest step
    wr(1'b1, 1'b1, 16'h8000, 8'h00);
    wait_apply(n);
    @(negedge clk);
    prev = pwm_out;
    c = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pwm_out != prev) c++;
      prev = pwm_out;
    end
    chk("R10 toggles every clock", c, 6);

    // disable then restart
    wr(1'b0, 1'b0, 16'h8000, 8'h00);
    chk("R8 low right after disable", int'(pwm_out), 0);
    count_high(10, c);
    chk("R8 stays low while disabled", c, 0);
    wr(1'b1, 1'b0, 16'h8000, 8'h00);
    seq[0] = pwm_out;
    for (int i = 1; i < 4; i++) begin @(negedge clk); seq[i] = pwm_out; end
    chk("R8 restart from zero phase", int'(seq), 4'b0100);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule